// File: doc/BRIEF.md
# Privileged Time-Stamp Counter Unit

This block keeps a free-running cycle counter and answers read requests for it. Each request comes with the requester's privilege context, and the block checks that context before it releases the count. A permitted read returns the count split into an upper and a lower half. Each half is zero-extended to the width of a destination register. A refused read returns an exception code and zeroed data.

Two request flavours share one port. The instruction-style read is governed by a disable flag, the privilege level, the protection-enable flag and the virtual-8086 flag. The model-register-style read is open only to the most privileged level. A lock-prefixed request is always rejected as an undefined opcode. Every request is answered exactly one cycle later. The answer carries the count value present in the request cycle.

Top module: `tsc_unit`

## Requirements
- R1: The counter increases by exactly one on every clock cycle, so two reads taken N cycles apart return values that differ by N.
- R2: Reset (active-low `rst_n`) clears the counter to zero. A read presented in the first cycle after reset is released returns zero, and while reset is held `rspValid` is 0 and both data outputs are 0.
- R3: A request with `reqValid`=1 in cycle T gives `rspValid`=1 in cycle T+1. The returned data is the count value during cycle T. With no request, `rspValid` stays 0 in the next cycle.
- R4: On a permitted read, `rspHigh` carries count bits [63:32] and `rspLow` carries count bits [31:0]. Bits [63:32] of both outputs are zero.
- R5: When `reqMsr`=0 and `v86Mode`=0, the read is permitted (`rspExc`=0) if `tsDisable`=0, or `privLevel`=0, or `protEnable`=0.
- R6: When `reqMsr`=0 and `v86Mode`=0 and `tsDisable`=1 and `protEnable`=1 and `privLevel` is 1, 2 or 3, the response has `rspExc`=1 (general protection, error code zero) and both data outputs are zero.
- R7: When `reqMsr`=0 and `v86Mode`=1, the read faults with `rspExc`=1 if `tsDisable`=1 and is permitted if `tsDisable`=0, whatever the privilege level.
- R8: A request with `lockPrefix`=1 answers `rspExc`=2 (undefined opcode) with zero data in every mode and for both flavours. This check overrides the general-protection check.
- R9: A request with `reqMsr`=1 returns the same split count as R4 when `privLevel`=0 and `v86Mode`=0, ignoring `tsDisable` and `protEnable`. Any other privilege level, or `v86Mode`=1, gives `rspExc`=1.
- R10: The counter wraps from all ones to zero without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request strobe |
| reqMsr | input | 1 | 1 = model-register-style read, 0 = instruction-style read |
| privLevel | input | 2 | Current privilege level, 0 most privileged |
| tsDisable | input | 1 | Restricts instruction-style reads to level 0 when set |
| protEnable | input | 1 | Protected operation active |
| v86Mode | input | 1 | Virtual-8086 operation active |
| lockPrefix | input | 1 | Request carried a lock prefix |
| rspValid | output | 1 | One-cycle response pulse |
| rspExc | output | 2 | 0 none, 1 general protection (code 0), 2 undefined opcode |
| rspHigh | output | 64 | Upper count half, zero-extended |
| rspLow | output | 64 | Lower count half, zero-extended |

## Verification
The bench sweeps the privilege matrix so that each gate condition is tested alone. This covers real mode with a raised level, level 0 with the disable flag set, virtual-8086 mode with the flag set and clear, and both read flavours. A design that folded virtual-8086 mode into the level check, or let the model-register path obey the disable flag, would return data where a fault is expected. The bench also checks lock-prefixed requests that would otherwise fault: a design with the checks in the wrong order reports general protection instead of undefined opcode. A narrow instance of the block is read across its wrap point. Back-to-back reads taken just after reset show whether the data is sampled one cycle late or the counter resets to a nonzero value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_GP   = 2'd1,
    EXC_UD   = 2'd2
  } excCode_t;

  // strobes from the permission control to the count datapath
  typedef struct packed {
    logic     capture;
    logic     zeroData;
    excCode_t exc;
  } ctrlStrobe_t;

endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic            reqMsr,
  input  logic [PL_W-1:0] privLevel,
  input  logic            tsDisable,
  input  logic            protEnable,
  input  logic            v86Mode,
  input  logic            lockPrefix,
  output ctrlStrobe_t     strobe,
  output logic            rspValid,
  output excCode_t        rspExc
);

  logic     plZero;
  logic     insnOk;
  logic     msrOk;
  logic     grant;
  excCode_t excNow;

  always_comb begin
    plZero = (privLevel == '0);
    if (v86Mode) begin
      insnOk = !tsDisable;
    end else begin
      insnOk = !tsDisable || plZero || !protEnable;
    end
    msrOk = plZero && !v86Mode;
    grant = reqMsr ? msrOk : insnOk;
    if (lockPrefix) begin
      excNow = EXC_UD;
    end else if (grant) begin
      excNow = EXC_NONE;
    end else begin
      excNow = EXC_GP;
    end
    strobe.capture  = reqValid;
    strobe.zeroData = (excNow != EXC_NONE);
    strobe.exc      = excNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspExc   <= EXC_NONE;
    end else begin
      rspValid <= reqValid;
      rspExc   <= reqValid ? excNow : EXC_NONE;
    end
  end

  assert_lock_ud_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && lockPrefix) |=> (rspValid && rspExc == EXC_UD));

  assert_msr_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqMsr && !lockPrefix && privLevel != '0) |=> (rspExc == EXC_GP));

  assert_v86_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqMsr && !lockPrefix && v86Mode && tsDisable) |=> (rspExc == EXC_GP));

  assert_level0_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqMsr && !lockPrefix && !v86Mode && privLevel == '0) |=> (rspExc == EXC_NONE));

endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  output logic [REG_W-1:0]  rspHigh,
  output logic [REG_W-1:0]  rspLow
);

  localparam int TOP_W = CNT_W - HALF_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
    end else if (strobe.capture) begin
      dataReg <= strobe.zeroData ? '0 : count;
    end
  end

  generate
    if (REG_W > HALF_W) begin : g_ext
      assign rspHigh = {{(REG_W - TOP_W){1'b0}}, dataReg[CNT_W-1:HALF_W]};
      assign rspLow  = {{(REG_W - HALF_W){1'b0}}, dataReg[HALF_W-1:0]};
    end else begin : g_flat
      assign rspHigh = dataReg[CNT_W-1:HALF_W];
      assign rspLow  = dataReg[HALF_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
  import tsc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32,
  parameter int REG_W  = 64,
  parameter int PL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqMsr,
  input  logic [PL_W-1:0]   privLevel,
  input  logic              tsDisable,
  input  logic              protEnable,
  input  logic              v86Mode,
  input  logic              lockPrefix,
  output logic              rspValid,
  output logic [1:0]        rspExc,
  output logic [REG_W-1:0]  rspHigh,
  output logic [REG_W-1:0]  rspLow
);

  ctrlStrobe_t strobe;
  excCode_t    excReg;

  tsc_ctrl #(.PL_W(PL_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqMsr     (reqMsr),
    .privLevel  (privLevel),
    .tsDisable  (tsDisable),
    .protEnable (protEnable),
    .v86Mode    (v86Mode),
    .lockPrefix (lockPrefix),
    .strobe     (strobe),
    .rspValid   (rspValid),
    .rspExc     (excReg)
  );

  tsc_datapath #(.CNT_W(CNT_W), .HALF_W(HALF_W), .REG_W(REG_W)) data_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .rspHigh (rspHigh),
    .rspLow  (rspLow)
  );

  assign rspExc = excReg;

  assert_fault_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && excReg != EXC_NONE) |-> (rspHigh == '0 && rspLow == '0));

  assert_idle_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  assert_pulse_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

endmodule

// File: tb/tsc_unit_tb_top.sv
`timescale 1ns/1ps
module tsc_unit_tb_top;

  localparam int NV = 17;
  // {msr, pl[1:0], tsd, pe, v86, lock, exp[1:0]}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_11_0_1_0_0_00, // R5 flag clear
    9'b0_00_1_1_0_0_00, // R5 level 0
    9'b0_11_1_0_0_0_00, // R5 protection off
    9'b0_11_1_1_0_0_01, // R6
    9'b0_01_1_1_0_0_01, // R6
    9'b0_10_1_1_0_0_01, // R6
    9'b0_11_0_1_1_0_00, // R7 open
    9'b0_11_1_1_1_0_01, // R7 fault
    9'b0_00_0_1_0_1_10, // R8
    9'b0_11_1_1_0_1_10, // R8 priority
    9'b0_00_0_0_0_1_10, // R8 real
    9'b1_00_1_1_0_0_00, // R9 level 0
    9'b1_01_0_1_0_0_01, // R9
    9'b1_11_0_0_0_0_01, // R9
    9'b1_11_0_1_0_1_10, // R8 msr
    9'b1_00_0_1_0_0_00, // R9
    9'b0_10_1_1_1_1_10  // R8 v86
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqMsr = 1'b0, tsDisable = 1'b0, protEnable = 1'b0;
  logic v86Mode = 1'b0, lockPrefix = 1'b0;
  logic [1:0] privLevel = 2'd0;
  logic rspValid, nValid;
  logic [1:0] rspExc, nExc;
  logic [63:0] rspHigh, rspLow;
  logic [7:0] nHigh, nLow;

  int checks = 0;
  int failures = 0;
  longint unsigned edgeCount = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edgeCount <= 0;
    else edgeCount <= edgeCount + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  tsc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMsr(reqMsr),
    .privLevel(privLevel), .tsDisable(tsDisable), .protEnable(protEnable),
    .v86Mode(v86Mode), .lockPrefix(lockPrefix), .rspValid(rspValid),
    .rspExc(rspExc), .rspHigh(rspHigh), .rspLow(rspLow)
  );

  tsc_unit #(.CNT_W(8), .HALF_W(4), .REG_W(8)) dut_n (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMsr(reqMsr),
    .privLevel(privLevel), .tsDisable(tsDisable), .protEnable(protEnable),
    .v86Mode(v86Mode), .lockPrefix(lockPrefix), .rspValid(nValid),
    .rspExc(nExc), .rspHigh(nHigh), .rspLow(nLow)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    reqValid   = 1'b1;
    reqMsr     = v[8];
    privLevel  = v[7:6];
    tsDisable  = v[5];
    protEnable = v[4];
    v86Mode    = v[3];
    lockPrefix = v[2];
  endtask

  task automatic checkMain(input string tag, input logic [1:0] expExc, input longint unsigned cnt);
    logic [63:0] c;
    c = (expExc == 2'd0) ? 64'(cnt) : 64'd0;
    chk({tag, " valid"}, 64'(rspValid), 64'd1);
    chk({tag, " exc"}, 64'(rspExc), 64'(expExc));
    chk({tag, " high"}, rspHigh, {32'd0, c[63:32]});
    chk({tag, " low"}, rspLow, {32'd0, c[31:0]});
  endtask

  initial begin
    longint unsigned expCnt;
    longint unsigned expCnt2;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 valid in reset", 64'(rspValid), 64'd0);
    chk("R2 high in reset", rspHigh, 64'd0);
    chk("R2 low in reset", rspLow, 64'd0);
    // R2: read in first cycle out of reset returns zero
    rst_n = 1'b1;
    drive(9'b0_00_0_1_0_0_00);
    expCnt = edgeCount;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 first read", rspLow, 64'd0);
    checkMain("R2", 2'd0, expCnt);

    // table walk: R4 R5 R6 R7 R8 R9, with varying gaps for R1 R3
    for (int i = 0; i < NV; i++) begin
      repeat (i % 3) @(negedge clk);
      drive(VEC[i]);
      expCnt = edgeCount;
      @(negedge clk);
      reqValid = 1'b0;
      checkMain($sformatf("R4/R5-R9 vec%0d", i), VEC[i][1:0], expCnt);
      @(negedge clk);
      chk($sformatf("R3 idle vec%0d", i), 64'(rspValid), 64'd0);
    end

    // R1: two reads a known distance apart
    drive(9'b0_00_0_1_0_0_00);
    @(negedge clk);
    reqValid = 1'b0;
    expCnt = {rspHigh[31:0], rspLow[31:0]};
    repeat (6) @(negedge clk);
    drive(9'b0_00_0_1_0_0_00);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 distance", {rspHigh[31:0], rspLow[31:0]} - expCnt, 64'd7);

    // R10: narrow instance across its wrap, back-to-back reads (R3)
    while ((edgeCount % 256) != 255) @(negedge clk);
    drive(9'b0_00_0_1_0_0_00);
    expCnt = edgeCount % 256;
    @(negedge clk);
    expCnt2 = edgeCount % 256;
    chk("R10 before wrap", {48'd0, nHigh, nLow}, {48'd0, 4'd0, expCnt[7:4], 4'd0, expCnt[3:0]});
    chk("R10 exc", 64'(nExc), 64'd0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 after wrap", {48'd0, nHigh, nLow}, {48'd0, 4'd0, expCnt2[7:4], 4'd0, expCnt2[3:0]});
    chk("R10 wrap zero", 64'(expCnt2), 64'd0);
    chk("R3 back-to-back valid", 64'(nValid), 64'd1);

    // R2: reset in mid-run clears the count again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 reset clears valid", 64'(rspValid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(9'b1_00_0_1_0_0_00);
    @(negedge clk);
    reqValid = 1'b0;
    checkMain("R2 R9 after reset", 2'd0, 64'd4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule